// File: doc/BRIEF.md
# Clip Window Method Decoder

This block takes method writes aimed at a drawing surface's clip window and turns them into the stored clip limits. Each axis has its own method offset. The 32-bit payload holds two values. The lower half is the first coordinate of the window. The upper half is a signed span measured from that coordinate.

For each write, the block does four things:

- It checks that the first coordinate is in range.
- It works out the last coordinate by adding the sign-extended span.
- It wraps that result to an 18-bit field.
- It loads the pair into the register set of the chosen axis.

A one-cycle accept or error pulse reports the outcome. The registered limits drive the rasterizer's clip compare, which lives outside this block.

A write lands on the first rising edge after the cycle in which it is presented. That same edge loads the registers and raises the outcome pulse. A write whose first coordinate has its top bit set is refused, and nothing is stored. A write to any other offset is not decoded at all.

Top module: `clip_window_decoder`

## Requirements
- R1: After reset, all four limit outputs read zero and both outcome pulses are low.
- R2: A valid write at offset 0x2F8 loads bits 15:0 of the data into the horizontal low limit. The vertical pair is left unchanged.
- R3: A valid write at offset 0x2FC loads bits 15:0 of the data into the vertical low limit. The horizontal pair is left unchanged.
- R4: If bit 15 of the data is set, the write is refused. The error pulse is high for exactly the one cycle after the write. The accept pulse stays low, and all four limits are unchanged.
- R5: When bit 31 of the data is set, the span in bits 31:16 is negative. It is sign-extended before the add, and the high limit is (start + span) modulo 2^18. For example, start 0 with span 0xFFFF gives 0x3FFFF.
- R6: When bit 31 is clear, the high limit is the unsigned sum start + span. The largest case, 0x7FFF + 0x7FFF, gives 0xFFFE.
- R7: An accepted write raises the accept pulse for the one cycle after the write. The limits change on that same edge, and the error pulse stays low.
- R8: A cycle in either of these two cases changes no limit and raises neither pulse:
  - the valid input is low, whatever the offset and data;
  - the valid input is high but the offset is neither 0x2F8 nor 0x2FC.
- R9: Writes on back-to-back cycles each take effect on their own edge, in order, with no cycle lost between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mw_valid | input | 1 | Method write strobe |
| mw_offset | input | 12 | Method offset; selects the axis |
| mw_data | input | 32 | Payload: span in 31:16, start in 15:0 |
| mw_accept | output | 1 | One-cycle pulse: the previous write was stored |
| mw_error | output | 1 | One-cycle pulse: the previous write was refused |
| clip_h_lo | output | 16 | Horizontal low limit |
| clip_h_hi | output | 18 | Horizontal high limit |
| clip_v_lo | output | 16 | Vertical low limit |
| clip_v_hi | output | 18 | Vertical high limit |

## Verification
Two things can land in the same cycle: the outcome pulse and register update of one write, and the decode of the next write. The bench provokes this by issuing writes back to back. The pairs used are:

- a refused write followed at once by an accepted one;
- a horizontal write followed at once by a vertical one.

After each edge it compares the pulses and all four limits against a model of its own. It also checks that the pulse from the earlier write never leaks into the later write's result, and that the refused write leaves the neighbouring axis untouched.

// File: rtl/clipdec_pkg.sv
package clipdec_pkg;

  // Index of each axis in the per-axis arrays
  localparam int AXIS_H = 0;
  localparam int AXIS_V = 1;
  localparam int N_AXES = 2;

  // Default geometry
  localparam int DEF_HALF_W = 16;
  localparam int DEF_END_W  = 18;
  localparam int DEF_OFS_W  = 12;

  // Outcome of one decoded cycle
  typedef enum logic [1:0] {
    OUT_IDLE   = 2'b00,
    OUT_ACCEPT = 2'b01,
    OUT_REFUSE = 2'b10
  } outcome_e;

endpackage

// File: rtl/clipdec_axis_sel.sv
module clipdec_axis_sel #(
  parameter int                 OFS_W  = 12,
  parameter logic [OFS_W-1:0]   H_OFS  = 12'h2F8,
  parameter logic [OFS_W-1:0]   V_OFS  = 12'h2FC
) (
  input  logic                             valid,
  input  logic [OFS_W-1:0]                 offset,
  output logic [clipdec_pkg::N_AXES-1:0]   hit
);
  import clipdec_pkg::*;

  localparam logic [OFS_W-1:0] AXIS_OFS [N_AXES] = '{H_OFS, V_OFS};

  // One comparator per axis
  for (genvar a = 0; a < N_AXES; a++) begin : g_cmp
    assign hit[a] = valid && (offset == AXIS_OFS[a]);
  end

endmodule

// File: rtl/clipdec_field_chk.sv
module clipdec_field_chk #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] data,
  output logic [HALF_W-1:0]   start,
  output logic [HALF_W-1:0]   span,
  output logic                start_ok
);
  always_comb begin
    start    = data[HALF_W-1:0];
    span     = data[2*HALF_W-1:HALF_W];
    // A start coordinate with its top bit set is out of range
    start_ok = ~data[HALF_W-1];
  end
endmodule

// File: rtl/clipdec_end_calc.sv
module clipdec_end_calc #(
  parameter int HALF_W = 16,
  parameter int END_W  = 18
) (
  input  logic [HALF_W-1:0] start,
  input  logic [HALF_W-1:0] span,
  output logic [END_W-1:0]  end_val
);
  localparam int PAD = END_W - HALF_W;

  logic [END_W-1:0] start_ext;
  logic [END_W-1:0] span_ext;

  if (PAD > 0) begin : g_wide
    // Zero-extend the start, sign-extend the span
    assign start_ext = {{PAD{1'b0}}, start};
    assign span_ext  = {{PAD{span[HALF_W-1]}}, span};
  end else begin : g_narrow
    assign start_ext = start[END_W-1:0];
    assign span_ext  = span[END_W-1:0];
  end

  // The END_W-bit adder drops the carry, which gives the wrap
  assign end_val = start_ext + span_ext;

endmodule

// File: rtl/clipdec_axis_reg.sv
module clipdec_axis_reg #(
  parameter int HALF_W = 16,
  parameter int END_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HALF_W-1:0] start,
  input  logic [END_W-1:0]  end_val,
  output logic [HALF_W-1:0] lo_q,
  output logic [END_W-1:0]  hi_q
);
  logic [HALF_W-1:0] lo_d;
  logic [END_W-1:0]  hi_d;

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (load) begin
      lo_d = start;
      hi_d = end_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/clip_window_decoder.sv
module clip_window_decoder #(
  parameter int               HALF_W = clipdec_pkg::DEF_HALF_W,
  parameter int               END_W  = clipdec_pkg::DEF_END_W,
  parameter int               OFS_W  = clipdec_pkg::DEF_OFS_W,
  parameter logic [OFS_W-1:0] H_OFS  = 12'h2F8,
  parameter logic [OFS_W-1:0] V_OFS  = 12'h2FC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mw_valid,
  input  logic [OFS_W-1:0]    mw_offset,
  input  logic [2*HALF_W-1:0] mw_data,
  output logic                mw_accept,
  output logic                mw_error,
  output logic [HALF_W-1:0]   clip_h_lo,
  output logic [END_W-1:0]    clip_h_hi,
  output logic [HALF_W-1:0]   clip_v_lo,
  output logic [END_W-1:0]    clip_v_hi
);
  import clipdec_pkg::*;

  // Reset: asserts at once, releases through two flops
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Decode
  logic [N_AXES-1:0] hit;
  logic [HALF_W-1:0] start, span;
  logic              start_ok;
  logic [END_W-1:0]  end_val;

  clipdec_axis_sel #(
    .OFS_W(OFS_W), .H_OFS(H_OFS), .V_OFS(V_OFS)
  ) u_sel (
    .valid  (mw_valid),
    .offset (mw_offset),
    .hit    (hit)
  );

  clipdec_field_chk #(.HALF_W(HALF_W)) u_fld (
    .data     (mw_data),
    .start    (start),
    .span     (span),
    .start_ok (start_ok)
  );

  clipdec_end_calc #(.HALF_W(HALF_W), .END_W(END_W)) u_end (
    .start   (start),
    .span    (span),
    .end_val (end_val)
  );

  // Per-axis register pairs
  logic [N_AXES-1:0] load;
  logic [HALF_W-1:0] lo_q [N_AXES];
  logic [END_W-1:0]  hi_q [N_AXES];

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    assign load[a] = hit[a] & start_ok;

    clipdec_axis_reg #(.HALF_W(HALF_W), .END_W(END_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .load    (load[a]),
      .start   (start),
      .end_val (end_val),
      .lo_q    (lo_q[a]),
      .hi_q    (hi_q[a])
    );
  end

  assign clip_h_lo = lo_q[AXIS_H];
  assign clip_h_hi = hi_q[AXIS_H];
  assign clip_v_lo = lo_q[AXIS_V];
  assign clip_v_hi = hi_q[AXIS_V];

  // Outcome pulses
  outcome_e out_d, out_q;

  always_comb begin
    out_d = OUT_IDLE;
    if (|hit) out_d = start_ok ? OUT_ACCEPT : OUT_REFUSE;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_q <= OUT_IDLE;
    else             out_q <= out_d;
  end

  assign mw_accept = (out_q == OUT_ACCEPT);
  assign mw_error  = (out_q == OUT_REFUSE);

endmodule

// File: rtl/clip_window_decoder_chk.sv
module clip_window_decoder_chk #(
  parameter int               HALF_W = 16,
  parameter int               END_W  = 18,
  parameter int               OFS_W  = 12,
  parameter logic [OFS_W-1:0] H_OFS  = 12'h2F8,
  parameter logic [OFS_W-1:0] V_OFS  = 12'h2FC
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                mw_valid,
  input logic [OFS_W-1:0]    mw_offset,
  input logic [2*HALF_W-1:0] mw_data,
  input logic                mw_accept,
  input logic                mw_error,
  input logic [HALF_W-1:0]   clip_h_lo,
  input logic [END_W-1:0]    clip_h_hi,
  input logic [HALF_W-1:0]   clip_v_lo,
  input logic [END_W-1:0]    clip_v_hi
);
  logic wr_h, wr_v, bad_start;
  logic [END_W-1:0] ref_end;

  assign wr_h      = mw_valid && (mw_offset == H_OFS);
  assign wr_v      = mw_valid && (mw_offset == V_OFS);
  assign bad_start = mw_data[HALF_W-1];
  assign ref_end   = END_W'({{HALF_W{1'b0}}, mw_data[HALF_W-1:0]} +
                     {{HALF_W{mw_data[2*HALF_W-1]}}, mw_data[2*HALF_W-1:HALF_W]});

  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mw_accept && mw_error));

  assert_refuse_holds_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past((wr_h || wr_v) && bad_start) |->
      (mw_error && !mw_accept && $stable(clip_h_lo) && $stable(clip_h_hi) &&
       $stable(clip_v_lo) && $stable(clip_v_hi)));

  assert_h_load_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_h && !bad_start) |->
      (mw_accept && clip_h_lo == $past(mw_data[HALF_W-1:0]) &&
       $stable(clip_v_lo) && $stable(clip_v_hi)));

  assert_v_load_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_v && !bad_start) |->
      (mw_accept && clip_v_lo == $past(mw_data[HALF_W-1:0]) &&
       $stable(clip_h_lo) && $stable(clip_h_hi)));

  assert_end_sum_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_h && !bad_start) |-> clip_h_hi == $past(ref_end));

  assert_end_sum_v_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(wr_v && !bad_start) |-> clip_v_hi == $past(ref_end));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!wr_h && !wr_v) |->
      (!mw_accept && !mw_error && $stable(clip_h_lo) && $stable(clip_h_hi) &&
       $stable(clip_v_lo) && $stable(clip_v_hi)));

endmodule

bind clip_window_decoder clip_window_decoder_chk #(
  .HALF_W(HALF_W), .END_W(END_W), .OFS_W(OFS_W), .H_OFS(H_OFS), .V_OFS(V_OFS)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .mw_valid   (mw_valid),
  .mw_offset  (mw_offset),
  .mw_data    (mw_data),
  .mw_accept  (mw_accept),
  .mw_error   (mw_error),
  .clip_h_lo  (clip_h_lo),
  .clip_h_hi  (clip_h_hi),
  .clip_v_lo  (clip_v_lo),
  .clip_v_hi  (clip_v_hi)
);

// File: tb/clip_window_decoder_tb.sv
`timescale 1ns/1ps
module clip_window_decoder_tb;
  localparam logic [11:0] OFS_H = 12'h2F8;
  localparam logic [11:0] OFS_V = 12'h2FC;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mw_valid;
  logic [11:0] mw_offset;
  logic [31:0] mw_data;
  logic        mw_accept, mw_error;
  logic [15:0] clip_h_lo, clip_v_lo;
  logic [17:0] clip_h_hi, clip_v_hi;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Reference state
  logic [15:0] e_hlo, e_vlo;
  logic [17:0] e_hhi, e_vhi;
  logic        e_acc, e_err;

  always #10 clk = ~clk;  // 50 MHz

  clip_window_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .mw_valid(mw_valid), .mw_offset(mw_offset),
    .mw_data(mw_data), .mw_accept(mw_accept), .mw_error(mw_error),
    .clip_h_lo(clip_h_lo), .clip_h_hi(clip_h_hi),
    .clip_v_lo(clip_v_lo), .clip_v_hi(clip_v_hi)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Work out what the design should hold after one write
  task automatic model(logic v, logic [11:0] ofs, logic [31:0] d);
    logic [31:0] sx;
    logic [17:0] hi;
    sx = d[31] ? {16'hFFFF, d[31:16]} : {16'h0000, d[31:16]};
    hi = 18'({16'h0000, d[15:0]} + sx);
    e_acc = 1'b0;
    e_err = 1'b0;
    if (v && (ofs == OFS_H || ofs == OFS_V)) begin
      if (d[15]) begin
        e_err = 1'b1;
      end else begin
        e_acc = 1'b1;
        if (ofs == OFS_H) begin e_hlo = d[15:0]; e_hhi = hi; end
        else              begin e_vlo = d[15:0]; e_vhi = hi; end
      end
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " accept"}, 32'(mw_accept), 32'(e_acc));
    chk({tag, " error"},  32'(mw_error),  32'(e_err));
    chk({tag, " h_lo"},   32'(clip_h_lo), 32'(e_hlo));
    chk({tag, " h_hi"},   32'(clip_h_hi), 32'(e_hhi));
    chk({tag, " v_lo"},   32'(clip_v_lo), 32'(e_vlo));
    chk({tag, " v_hi"},   32'(clip_v_hi), 32'(e_vhi));
  endtask

  task automatic do_write(string tag, logic v, logic [11:0] ofs, logic [31:0] d);
    @(negedge clk);
    mw_valid  = v;
    mw_offset = ofs;
    mw_data   = d;
    @(negedge clk);
    mw_valid = 1'b0;
    model(v, ofs, d);
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mw_valid = 1'b0;
    mw_offset = '0;
    mw_data = '0;
    e_hlo = '0; e_hhi = '0; e_vlo = '0; e_vhi = '0;
    e_acc = 1'b0; e_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset");

    // Corner cases
    do_write("R6 max positive",  1'b1, OFS_H, {16'h7FFF, 16'h7FFF});
    do_write("R5 wrap to 3FFFF", 1'b1, OFS_V, {16'hFFFF, 16'h0000});
    do_write("R5 negative to 0", 1'b1, OFS_H, {16'hFFFB, 16'h0005});
    do_write("R4 start 8000",    1'b1, OFS_H, {16'h0001, 16'h8000});
    do_write("R4 start FFFF",    1'b1, OFS_V, {16'h0000, 16'hFFFF});
    do_write("R8 other offset",  1'b1, 12'h2F4, {16'h0010, 16'h0020});
    do_write("R8 valid low",     1'b0, OFS_H, {16'h0011, 16'h0022});
    do_write("R2 horizontal",    1'b1, OFS_H, {16'h0100, 16'h0200});
    do_write("R3 vertical",      1'b1, OFS_V, {16'h0300, 16'h0400});

    // R9: refused then accepted, back to back
    @(negedge clk);
    mw_valid = 1'b1; mw_offset = OFS_V; mw_data = {16'h0005, 16'h9000};
    @(negedge clk);
    model(1'b1, OFS_V, {16'h0005, 16'h9000});
    check_all("R9 first refused");
    mw_offset = OFS_V; mw_data = {16'h8001, 16'h1000};
    @(negedge clk);
    mw_valid = 1'b0;
    model(1'b1, OFS_V, {16'h8001, 16'h1000});
    check_all("R9 second accepted");

    // R9: horizontal then vertical, back to back
    @(negedge clk);
    mw_valid = 1'b1; mw_offset = OFS_H; mw_data = {16'h0040, 16'h0123};
    @(negedge clk);
    model(1'b1, OFS_H, {16'h0040, 16'h0123});
    check_all("R9 first h");
    mw_offset = OFS_V; mw_data = {16'hFF00, 16'h0456};
    @(negedge clk);
    mw_valid = 1'b0;
    model(1'b1, OFS_V, {16'hFF00, 16'h0456});
    check_all("R9 second v");
    @(negedge clk);
    model(1'b0, OFS_H, 32'h0);
    check_all("R8 idle after burst");

    // Sweep: R5 and R6 sums, and R4 refusals, over both axes
    for (int i = 0; i < 23; i++) begin
      for (int j = 0; j < 23; j++) begin
        logic [15:0] s, e;
        s = 16'(i * 16'h0BA3);
        e = 16'(j * 16'h0B71);
        do_write("R5 R6 R4 sweep", 1'b1, ((i + j) % 2 == 1) ? OFS_V : OFS_H, {e, s});
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule